// File: doc/BRIEF.md
# Oversampling Averager

This block follows a successive-approximation converter core and turns a run of 2^n consecutive 12-bit conversion results into a single averaged value. Each accepted sample is added into a wide accumulator. When the final sample of the window arrives, the block scales the total and places it in a 16-bit result register. It then raises a one-cycle valid pulse. Samples from inside the window never reach the output.

The ratio exponent n runs from 1 to 12. For windows of 2 to 16 samples the total is passed through unscaled, so the result gains one bit of resolution per doubling, up to 16 bits. For larger windows the total is shifted right by n−4, which keeps the result at 16 bits. A mode flag selects how samples are read. When it is clear, samples are unsigned. When it is set, samples are 12-bit two's complement differential readings, and the accumulation and the shift are signed. A restart input, or any change of the ratio select, drops the partial window.

Top module: `ovs_avg`

## Requirements
- R1: While reset is asserted and after its release, `resultValid` is 0 and `result` is 0 until the first window completes.
- R2: A result is produced only after exactly 2^n samples have been accepted, where a sample counts in a cycle with `sampleValid` high. `resultValid` is high for exactly the one cycle that follows the clock edge accepting the last sample, and `result` updates on that same edge.
- R3: For n from 1 to 4 in unsigned mode (`diffMode`=0), `result` equals the plain sum of the samples, zero-extended to 16 bits, so that no bit at or above position 12+n is set.
- R4: For n from 5 to 12, `result` equals the sum shifted right by n−4 positions, keeping bits 15:0.
- R5: With `diffMode`=1, each sample is a 12-bit two's complement value with bit 11 as its sign. The sum is signed and the shift is arithmetic, so it rounds toward minus infinity. `result` is the 16-bit two's complement value.
- R6: `result` holds its value in every cycle in which no new result is produced.
- R7: A cycle with `restart` high discards the partial window, including any sample offered in that cycle. No result follows it until a full new window of 2^n samples has been accepted.
- R8: A cycle in which `ratioSel` differs from its value in the previous cycle discards the partial window, including any sample offered in that cycle. Counting restarts under the new ratio.
- R9: A `ratioSel` of 0 acts as n=1, and values from 13 to 15 act as n=12.
- R10: Cycles with `sampleValid` low do not advance the window, whatever `sampleIn` carries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleIn | input | 12 | Conversion result |
| sampleValid | input | 1 | Marks `sampleIn` as a new sample |
| ratioSel | input | 4 | Oversampling exponent n |
| diffMode | input | 1 | 1: signed differential samples, 0: unsigned |
| restart | input | 1 | Drops the partial window |
| result | output | 16 | Averaged result, held between windows |
| resultValid | output | 1 | One-cycle pulse when `result` is new |

## Verification
The bench builds the block with its default parameters: 12-bit samples, a maximum exponent of 12 and a 16-bit result. This puts the full 4096-sample window within reach, along with the eight-position shift and the accumulator's extreme totals in both unsigned and signed mode. With these values the bench also hits the boundary between the unshifted and shifted schedules (n=4 and n=5) and the clamping of out-of-range select codes.

// File: rtl/ovs_pkg.sv
package ovs_pkg;

  // Strobes passed from the window control to the datapath
  typedef struct packed {
    logic clearAcc;    // drop the partial sum
    logic addSample;   // fold sample into the sum, window continues
    logic emitResult;  // fold sample, scale, load result, clear sum
  } ovsStrobe_t;

  // Map a raw select code onto the legal exponent range 1..maxLog2
  function automatic int unsigned clampRatio(input int unsigned sel,
                                             input int unsigned maxLog2);
    if (sel == 0) return 1;
    if (sel > maxLog2) return maxLog2;
    return sel;
  endfunction

endpackage

// File: rtl/ovs_shifter.sv
// Logarithmic right shifter with a selectable fill bit (arithmetic or logical)
module ovs_shifter #(
  parameter int W    = 24,
  parameter int SH_W = 4
) (
  input  logic [W-1:0]    dataIn,
  input  logic [SH_W-1:0] shAmt,
  input  logic            fill,
  output logic [W-1:0]    dataOut
);

  logic [W-1:0] stage [SH_W+1];

  assign stage[0] = dataIn;

  for (genvar i = 0; i < SH_W; i++) begin : g_stage
    localparam int STEP = (1 << i);
    if (STEP < W) begin : g_part
      assign stage[i+1] = shAmt[i] ? {{STEP{fill}}, stage[i][W-1:STEP]} : stage[i];
    end else begin : g_full
      assign stage[i+1] = shAmt[i] ? {W{fill}} : stage[i];
    end
  end

  assign dataOut = stage[SH_W];

endmodule

// File: rtl/ovs_control.sv
// Window control: counts accepted samples, detects ratio changes, issues strobes
module ovs_control
  import ovs_pkg::*;
#(
  parameter int MAX_LOG2 = 12,
  parameter int SEL_W    = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sampleValid,
  input  logic [SEL_W-1:0] ratioSel,
  input  logic             restart,
  output ovsStrobe_t       strobe,
  output logic [SEL_W-1:0] nEff,
  output logic             resultValid
);

  logic [SEL_W-1:0]    ratioPrev;
  logic [MAX_LOG2-1:0] sampleCnt;
  logic [MAX_LOG2-1:0] lastCount;
  logic                ratioChanged;
  logic                isLast;
  logic                dropWindow;

  assign nEff = SEL_W'(clampRatio(int'(ratioSel), MAX_LOG2));

  // lastCount = 2^nEff - 1 as a thermometer mask
  always_comb begin
    for (int i = 0; i < MAX_LOG2; i++) begin
      lastCount[i] = (i < int'(nEff));
    end
  end

  assign ratioChanged = (ratioSel != ratioPrev);
  assign dropWindow   = restart | ratioChanged;
  assign isLast       = (sampleCnt == lastCount);

  always_comb begin
    strobe            = '0;
    strobe.clearAcc   = dropWindow;
    strobe.addSample  = sampleValid & ~dropWindow & ~isLast;
    strobe.emitResult = sampleValid & ~dropWindow & isLast;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampleCnt   <= '0;
      ratioPrev   <= '0;
      resultValid <= 1'b0;
    end else begin
      ratioPrev   <= ratioSel;
      resultValid <= strobe.emitResult;
      if (strobe.clearAcc || strobe.emitResult) begin
        sampleCnt <= '0;
      end else if (strobe.addSample) begin
        sampleCnt <= sampleCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/ovs_datapath.sv
// Accumulator, shift schedule and result register
module ovs_datapath
  import ovs_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int MAX_LOG2 = 12,
  parameter int RESULT_W = 16,
  parameter int SEL_W    = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  ovsStrobe_t          strobe,
  input  logic [SAMPLE_W-1:0] sampleIn,
  input  logic                diffMode,
  input  logic [SEL_W-1:0]    nEff,
  output logic [RESULT_W-1:0] result
);

  localparam int ACC_W = SAMPLE_W + MAX_LOG2;
  localparam int GROW  = RESULT_W - SAMPLE_W;

  logic [ACC_W-1:0]  acc;
  logic [ACC_W-1:0]  sampleExt;
  logic [ACC_W-1:0]  accSum;
  logic [ACC_W-1:0]  scaled;
  logic [SEL_W-1:0]  shiftAmt;
  logic              signBit;

  assign signBit   = diffMode & sampleIn[SAMPLE_W-1];
  assign sampleExt = {{MAX_LOG2{signBit}}, sampleIn};
  assign accSum    = acc + sampleExt;

  // No shift until the sum outgrows the result; then n - GROW
  assign shiftAmt = (nEff > SEL_W'(GROW)) ? (nEff - SEL_W'(GROW)) : '0;

  ovs_shifter #(
    .W    (ACC_W),
    .SH_W (SEL_W)
  ) u_shift (
    .dataIn  (accSum),
    .shAmt   (shiftAmt),
    .fill    (diffMode & accSum[ACC_W-1]),
    .dataOut (scaled)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc    <= '0;
      result <= '0;
    end else begin
      if (strobe.clearAcc) begin
        acc <= '0;
      end else if (strobe.emitResult) begin
        acc    <= '0;
        result <= scaled[RESULT_W-1:0];
      end else if (strobe.addSample) begin
        acc <= accSum;
      end
    end
  end

endmodule

// File: rtl/ovs_avg.sv
// Top: oversampling accumulate-and-shift averager
module ovs_avg
  import ovs_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int MAX_LOG2 = 12,
  parameter int RESULT_W = 16,
  parameter int SEL_W    = $clog2(MAX_LOG2 + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [SAMPLE_W-1:0] sampleIn,
  input  logic                sampleValid,
  input  logic [SEL_W-1:0]    ratioSel,
  input  logic                diffMode,
  input  logic                restart,
  output logic [RESULT_W-1:0] result,
  output logic                resultValid
);

  ovsStrobe_t       strobe;
  logic [SEL_W-1:0] nEff;

  ovs_control #(
    .MAX_LOG2 (MAX_LOG2),
    .SEL_W    (SEL_W)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .sampleValid (sampleValid),
    .ratioSel    (ratioSel),
    .restart     (restart),
    .strobe      (strobe),
    .nEff        (nEff),
    .resultValid (resultValid)
  );

  ovs_datapath #(
    .SAMPLE_W (SAMPLE_W),
    .MAX_LOG2 (MAX_LOG2),
    .RESULT_W (RESULT_W),
    .SEL_W    (SEL_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .sampleIn (sampleIn),
    .diffMode (diffMode),
    .nEff     (nEff),
    .result   (result)
  );

endmodule

// File: rtl/ovs_avg_chk.sv
// Property checker, attached to every ovs_avg instance
module ovs_avg_chk #(
  parameter int SAMPLE_W = 12,
  parameter int MAX_LOG2 = 12,
  parameter int RESULT_W = 16,
  parameter int SEL_W    = 4
) (
  input logic                clk,
  input logic                rstN,
  input logic [SAMPLE_W-1:0] sampleIn,
  input logic                sampleValid,
  input logic [SEL_W-1:0]    ratioSel,
  input logic                diffMode,
  input logic                restart,
  input logic [RESULT_W-1:0] result,
  input logic                resultValid
);

  int unsigned nChk;
  assign nChk = (ratioSel == 0) ? 1 : ((int'(ratioSel) > MAX_LOG2) ? MAX_LOG2 : int'(ratioSel));

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rstN |=> !resultValid);

  // R2
  valid_needs_sample_chk: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> $past(sampleValid));

  // R2
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);

  // R3
  unsigned_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resultValid && !diffMode && nChk <= 4) |-> ((32'(result) >> (SAMPLE_W + nChk)) == 0));

  // R6
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !resultValid |-> $stable(result));

  // R7
  restart_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    restart |=> !resultValid);

  // R8
  ratio_change_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ratioSel != $past(ratioSel)) |=> !resultValid);

  wire unusedChk = ^sampleIn;

endmodule

bind ovs_avg ovs_avg_chk #(
  .SAMPLE_W (SAMPLE_W),
  .MAX_LOG2 (MAX_LOG2),
  .RESULT_W (RESULT_W),
  .SEL_W    (SEL_W)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .sampleIn    (sampleIn),
  .sampleValid (sampleValid),
  .ratioSel    (ratioSel),
  .diffMode    (diffMode),
  .restart     (restart),
  .result      (result),
  .resultValid (resultValid)
);

// File: tb/sim_ovs_avg.sv
`timescale 1ns/1ps
module sim_ovs_avg;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] sampleIn = '0;
  logic        sampleValid = 1'b0;
  logic [3:0]  ratioSel = 4'd1;
  logic        diffMode = 1'b0;
  logic        restart = 1'b0;
  logic [15:0] result;
  logic        resultValid;

  int compared = 0;
  int mismatched = 0;

  logic [15:0] expQ [$];
  string       tagQ [$];
  logic [15:0] lastExp = '0;

  always #10 clk = ~clk;  // 50 MHz

  ovs_avg u0 (
    .clk         (clk),
    .rstN        (rstN),
    .sampleIn    (sampleIn),
    .sampleValid (sampleValid),
    .ratioSel    (ratioSel),
    .diffMode    (diffMode),
    .restart     (restart),
    .result      (result),
    .resultValid (resultValid)
  );

  function automatic int effN(input int sel);
    if (sel == 0) return 1;
    if (sel > 12) return 12;
    return sel;
  endfunction

  function automatic longint sval(input logic [11:0] v, input bit diff);
    if (diff && v[11]) return longint'(v) - 4096;
    return longint'(v);
  endfunction

  function automatic logic [15:0] scaleSum(input longint sum, input int n);
    longint s;
    s = (n > 4) ? (sum >>> (n - 4)) : sum;
    return s[15:0];
  endfunction

  function automatic logic [11:0] genSample(input int seed, input int i, input int kind);
    case (kind)
      1: return 12'hFFF;
      2: return 12'h800;
      3: return 12'h7FF;
      default: return 12'(((seed + i) * 1103) + (i * i * 7) + seed * 31);
    endcase
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: pop and compare every produced result
  always @(negedge clk) begin
    if (rstN && resultValid) begin
      compared++;
      if (expQ.size() == 0) begin
        mismatched++;
        $display("FAIL R2: actual unexpected result %h expected none", result);
      end else begin
        logic [15:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        lastExp = e;
        if (result !== e) begin
          mismatched++;
          $display("FAIL %s: actual %h expected %h", t, result, e);
        end
      end
    end
  end

  // Called at a falling edge; offers one sample, then idles gap cycles
  task automatic pushSample(input logic [11:0] v, input int gap);
    sampleIn = v;
    sampleValid = 1'b1;
    @(negedge clk);
    sampleValid = 1'b0;
    sampleIn = ~v;  // garbage while idle (R10)
    repeat (gap) @(negedge clk);
  endtask

  task automatic setMode(input int sel, input bit diff);
    ratioSel = 4'(sel);
    diffMode = diff;
    @(negedge clk);
  endtask

  // Driver: one full window, expected value pushed to the scoreboard
  task automatic runWindow(input int sel, input bit diff, input int seed,
                           input int kind, input string tag);
    int n;
    longint sum;
    n = effN(sel);
    if (ratioSel != 4'(sel) || diffMode != diff) setMode(sel, diff);
    sum = 0;
    for (int i = 0; i < (1 << n); i++) sum += sval(genSample(seed, i, kind), diff);
    expQ.push_back(scaleSum(sum, n));
    tagQ.push_back(tag);
    for (int i = 0; i < (1 << n); i++)
      pushSample(genSample(seed, i, kind), (seed % 2 == 1 && i % 3 == 0) ? 1 : 0);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 valid in reset", {15'd0, resultValid}, 16'd0);
    check("R1 result in reset", result, 16'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 valid after reset", {15'd0, resultValid}, 16'd0);
    check("R1 result after reset", result, 16'd0);

    // R3: unshifted windows, unsigned
    runWindow(1, 0, 3, 0, "R3 n1");
    runWindow(1, 0, 0, 1, "R3 n1 fullscale");
    runWindow(2, 0, 5, 0, "R3 n2");
    runWindow(3, 0, 8, 0, "R3 n3");
    runWindow(4, 0, 9, 0, "R3 n4");
    runWindow(4, 0, 0, 1, "R3 n4 fullscale");
    // R4: shifted windows
    runWindow(5, 0, 11, 0, "R4 n5");
    runWindow(5, 0, 0, 1, "R4 n5 fullscale");
    runWindow(8, 0, 13, 0, "R4 n8");
    runWindow(12, 0, 0, 1, "R4 n12 fullscale");
    // R5: signed differential
    runWindow(2, 1, 7, 0, "R5 n2 signed");
    runWindow(4, 1, 0, 2, "R5 n4 most negative");
    runWindow(6, 1, 17, 0, "R5 n6 signed");
    runWindow(12, 1, 0, 2, "R5 n12 most negative");
    runWindow(12, 1, 0, 3, "R5 n12 most positive");

    // R6: result holds through idle cycles
    repeat (10) @(negedge clk);
    check("R6 hold", result, lastExp);

    // R7: restart drops partial window and the sample offered with it
    setMode(3, 0);
    for (int i = 0; i < 5; i++) pushSample(12'hABC, 0);
    restart = 1'b1;
    pushSample(12'hFFF, 0);
    restart = 1'b0;
    check("R7 no result after restart", {15'd0, resultValid}, 16'd0);
    runWindow(3, 0, 21, 0, "R7 fresh window");

    // R8: ratio change drops partial window and the sample in that cycle
    for (int i = 0; i < 3; i++) pushSample(12'h555, 0);
    ratioSel = 4'd2;
    pushSample(12'hFFF, 0);
    check("R8 no result after change", {15'd0, resultValid}, 16'd0);
    runWindow(2, 0, 23, 0, "R8 new ratio");

    // R9: clamped selects
    runWindow(0, 0, 25, 0, "R9 sel0 acts as n1");
    runWindow(15, 0, 27, 0, "R9 sel15 acts as n12");
    runWindow(13, 1, 0, 2, "R9 sel13 signed");

    // R10: windows with idle gaps and garbage (odd seeds insert gaps)
    runWindow(3, 0, 31, 0, "R10 gapped n3");
    runWindow(7, 1, 33, 0, "R10 gapped n7 signed");

    // R2: every queued result arrived, none extra
    repeat (5) @(negedge clk);
    check("R2 all results seen", 16'(expQ.size()), 16'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule